// File: doc/BRIEF.md
# Narrow Strobe Event Synchroniser

This block carries one event from an external strobe into a destination clock domain and reports it there as a pulse exactly one clock wide. The strobe can be far shorter than a destination clock period, so it is never sampled directly. Its rising edge clocks a capture flop whose D input is tied high. That flop's state then passes through a two-flop synchroniser. Edge logic in the destination domain shapes the single-cycle output. A registered destination-side signal then clears the capture flop asynchronously, which makes it ready for the next event.

Strobes that arrive while an event is still in flight are merged into the pending pulse. A parameter selects how the output pulse is formed. One choice is a gate that combines the second synchroniser stage with the inverted state of a third flop. The other is a third flop that resets synchronously, so that no gate sits between the second stage and the output register.

Top module: `strobe_catch`

## Requirements
- R1: While rst_n is low and after its release, pulse_o stays low until a strobe rising edge occurs after release; a strobe during reset produces no pulse.
- R2: Each isolated strobe rising edge, even one much narrower than a clock period, yields exactly one pulse_o of one clock cycle.
- R3: With REG_OUT = 0, a strobe that rises between edges k and k+1 makes pulse_o high in the cycle that follows edge k+2.
- R4: With REG_OUT = 1, the same strobe makes pulse_o high in the cycle that follows edge k+3, one cycle later than R3.
- R5: Further strobe edges that arrive while an event is pending, from capture until the clear releases (between edges k+1 and k+6), add no pulse.
- R6: The capture flop is cleared only by a registered destination-domain clear or by reset. The clear releases after edge k+6.
- R7: A strobe that rises after edge k+6 is captured as a new event and yields its own pulse.
- R8: Asserting reset while an event is between capture and output discards it, and no pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Destination clock |
| rst_n | input | 1 | Asynchronous active-low reset for all stages |
| evt_strobe | input | 1 | External event strobe; its rising edge marks an event |
| pulse_o | output | 1 | One-cycle event pulse in the clk domain |

## Verification
The bench builds two copies side by side: one with REG_OUT = 0 (gated shaping) and one with REG_OUT = 1 (registered shaping). Both are driven from the same 1 ns strobe. This places the exact one-cycle latency difference between the two shaping variants within reach, and it tests merge, clear-release spacing and mid-flight reset against both at once.

// File: rtl/strobe_catch.sv
module strobe_catch #(
  parameter bit REG_OUT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_strobe,
  output logic pulse_o
);

  logic flag_q;
  logic sync1_q, sync2_q;
  logic clr_q;
  logic flag_clr;

  assign flag_clr = clr_q | ~rst_n;

  always_ff @(posedge evt_strobe or posedge flag_clr) begin
    if (flag_clr) flag_q <= 1'b0;
    else          flag_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      sync1_q <= flag_q;
      sync2_q <= sync1_q;
      clr_q   <= sync2_q;
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      logic third_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     third_q <= 1'b0;
        else if (clr_q) third_q <= 1'b0;
        else            third_q <= sync2_q;
      end
      assign pulse_o = third_q;

      a_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync2_q) |=> pulse_o);
    end else begin : g_gate
      assign pulse_o = sync2_q & ~clr_q;

      a_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync2_q) |-> pulse_o);
    end
  endgenerate

  always @(posedge clk) begin
    if (!rst_n) a_reset_quiet_R1: assert (!pulse_o);
  end

  a_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

  a_merge_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o ##1 !pulse_o ##1 !pulse_o);

  a_clear_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync1_q) |-> $past(clr_q));

endmodule

// File: tb/strobe_catch_test.sv
module strobe_catch_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_strobe = 1'b0;
  logic pulse_gate, pulse_reg;
  int   cyc = 0;
  int   n_tests = 0;
  int   n_fail = 0;
  bit   run = 1'b0;
  string phase = "R1";
  int   q_gate[$];
  int   q_reg[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  strobe_catch #(.REG_OUT(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe), .pulse_o(pulse_gate));
  strobe_catch #(.REG_OUT(1'b1)) uut_reg (
    .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe), .pulse_o(pulse_reg));

  task automatic strobe(input bit expect_pulse);
    @(negedge clk);
    #0.5 evt_strobe = 1'b1;
    #1   evt_strobe = 1'b0;
    if (expect_pulse) begin
      q_gate.push_back(cyc + 2);
      q_reg.push_back(cyc + 3);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (run) begin
      bit exp_g, exp_r;
      exp_g = (q_gate.size() > 0) && (q_gate[0] == cyc);
      exp_r = (q_reg.size() > 0) && (q_reg[0] == cyc);
      if (pulse_gate || exp_g) begin
        n_tests++;
        if (pulse_gate !== exp_g) begin
          n_fail++;
          $display("FAIL %s/R3 gated cyc=%0d actual=%b expected=%b", phase, cyc, pulse_gate, exp_g);
        end
        if (exp_g) void'(q_gate.pop_front());
      end
      if (pulse_reg || exp_r) begin
        n_tests++;
        if (pulse_reg !== exp_r) begin
          n_fail++;
          $display("FAIL %s/R4 registered cyc=%0d actual=%b expected=%b", phase, cyc, pulse_reg, exp_r);
        end
        if (exp_r) void'(q_reg.pop_front());
      end
    end
  end

  initial begin
    #1000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    run = 1'b1;
    // R1: strobe during reset, no pulse
    phase = "R1";
    strobe(1'b0);
    idle(3);
    n_tests++;
    if (pulse_gate !== 1'b0 || pulse_reg !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 during reset actual=%b%b expected=00", pulse_gate, pulse_reg);
    end
    @(negedge clk) rst_n = 1'b1;
    idle(8);
    // R2, R3, R4: isolated narrow strobes
    phase = "R2";
    strobe(1'b1); idle(12);
    strobe(1'b1); idle(9);
    // R5: extra strobes while pending merge
    phase = "R5";
    strobe(1'b1);
    strobe(1'b0); strobe(1'b0); strobe(1'b0); strobe(1'b0); strobe(1'b0);
    idle(10);
    // R7: new strobe right after the clear releases (R6 timing)
    phase = "R7";
    strobe(1'b1);
    idle(5);
    strobe(1'b1);
    idle(12);
    // R8: reset while an event is in flight
    phase = "R8";
    strobe(1'b0);
    @(negedge clk) rst_n = 1'b0;
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(10);
    phase = "R2";
    strobe(1'b1); idle(10);
    run = 1'b0;
    n_tests++;
    if (q_gate.size() != 0 || q_reg.size() != 0) begin
      n_fail++;
      $display("FAIL R2 missing pulses actual=%0d/%0d expected=0/0", q_gate.size(), q_reg.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule